// File: doc/BRIEF.md
# Egress Training Scheduler and DIP-4 Error Injector

This block sits on the transmit side of a 16-lane SPI-4.2 style data path, between the word source and the line. Each cycle it forwards one 16-bit word with a control flag. On a programmable period it takes the line away from the source and sends a burst of the fixed training pattern. While the burst runs, the source is held off with a ready signal. A burst always starts where a control word would begin, so a packet's data words are never split.

For diagnostics, software can arm a one-shot error insertion. It corrupts the DIP-4 code of a set number of later source control words, and its busy flag then drops by itself. A second diagnostic delays lane 0 alone by up to three bit times. A DIP-4 code already sits in bits [3:0] of every control word the source supplies; this block does not compute it.

Top module: `egress_train_inj`

## Requirements
- R1: After reset, `out_valid`, `out_ctrl`, `out_train`, `out_word` and `ins_busy` are 0, and `in_ready` is 1.
- R2: When `cfg_max_t` = T is nonzero and the source is idle, exactly T non-training output cycles separate the end of one training burst from the start of the next. The period counter restarts when a burst completes.
- R3: A burst is (`cfg_alpha`+1) copies of a 21-word pattern, each word flagged by `out_train` = 1. Each copy is one idle control word 0x0F0F, then ten control words 0x0FFF, then ten data words 0xF000.
- R4: A burst starts only in a cycle where the source presents a control word or nothing. `in_ready` is 0 for every cycle of the burst. A held word passes unchanged after the burst, and the first source word after a burst within a continuous stream is a control word.
- R5: When `cfg_max_t` is 0, no training word is sent.
- R6: A one-cycle `ins_set` pulse with `cfg_err_cnt` = N > 0 raises `ins_busy` on the next cycle. The next N source control words pass with bit 0 inverted, and `ins_busy` falls on the same cycle the Nth corrupted word appears. Data words are never altered. A pulse while `ins_busy` is 1 is ignored.
- R7: An `ins_set` pulse with `cfg_err_cnt` = 0 leaves `ins_busy` at 0 and corrupts no word.
- R8: Training words are never corrupted. An armed insertion waits through a burst and applies to later source control words.
- R9: With `cfg_bit_dly` = d (0 to 3), bit 0 of `out_word` carries the lane-0 value of the output from d cycles earlier. Bits [15:1] are not delayed. Lane 0 is 0 on idle cycles.
- R10: An accepted source word appears one cycle later with `out_valid` = 1, `out_train` = 0, the same control flag, and bits [15:1] unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source word present |
| in_ctrl | input | 1 | Source word is a control word |
| in_word | input | 16 | Source word; DIP-4 code in bits [3:0] of control words |
| in_ready | output | 1 | Source word accepted this cycle |
| cfg_alpha | input | 8 | Pattern repetitions per burst, minus one |
| cfg_max_t | input | 16 | Cycles between bursts; 0 disables training |
| cfg_err_cnt | input | 4 | Number of control words to corrupt |
| ins_set | input | 1 | Pulse that arms the error insertion |
| cfg_bit_dly | input | 2 | Lane-0 delay in bit times |
| ins_busy | output | 1 | Error insertion armed and not yet finished |
| out_valid | output | 1 | Output word present |
| out_ctrl | output | 1 | Output word is a control word |
| out_train | output | 1 | Output word belongs to a training burst |
| out_word | output | 16 | Output lane data |

## Verification
A due training burst and a pending DIP-4 corruption can meet in one cycle: a source control word arrives just as the burst is allowed to start. The bench provokes this by streaming packets back to back while an insertion of several errors is armed and the period is short, so bursts keep landing on packet heads. A scoreboard then judges each source word. Every held control word must come out after its burst, and corrupted exactly when the bench's own count of remaining errors says so. Each training word is compared against the fixed pattern, so a corruption that leaks into a burst is caught.

// File: rtl/trn_pkg.sv
package trn_pkg;
    localparam int DATA_W     = 16;
    localparam int TRAIN_REPS = 10;
    localparam int PAT_LEN    = 1 + 2 * TRAIN_REPS;
    localparam logic [DATA_W-1:0] IDLE_CW = 16'h0F0F;
    localparam logic [DATA_W-1:0] TRN_CW  = 16'h0FFF;
    localparam logic [DATA_W-1:0] TRN_DW  = 16'hF000;

    typedef struct packed {
        logic              ctrl;
        logic [DATA_W-1:0] word;
    } lane_word_t;

    // Word at a given position of one copy of the training pattern
    function automatic lane_word_t pat_word(input int unsigned idx);
        lane_word_t w;
        if (idx == 0) begin
            w.ctrl = 1'b1;
            w.word = IDLE_CW;
        end else if (idx <= TRAIN_REPS) begin
            w.ctrl = 1'b1;
            w.word = TRN_CW;
        end else begin
            w.ctrl = 1'b0;
            w.word = TRN_DW;
        end
        return w;
    endfunction
endpackage

// File: rtl/trn_sched.sv
module trn_sched
    import trn_pkg::*;
#(
    parameter int ALPHA_W = 8,
    parameter int MAXT_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ALPHA_W-1:0] cfg_alpha,
    input  logic [MAXT_W-1:0]  cfg_max_t,
    input  logic               in_valid,
    input  logic               in_ctrl,
    output logic               active,
    output lane_word_t         tr,
    output logic               in_ready
);
    localparam int IDX_W = $clog2(PAT_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_LEN - 1);

    logic [MAXT_W-1:0]  cnt;
    logic               pending;
    logic               in_train;
    logic [IDX_W-1:0]   idx;
    logic [ALPHA_W-1:0] rep;

    logic               start;
    logic [IDX_W-1:0]   cur_idx;
    logic [ALPHA_W-1:0] cur_rep;

    // A burst may open only where no data word of a packet is waiting
    assign start    = pending && !in_train && (!in_valid || in_ctrl);
    assign active   = in_train || start;
    assign cur_idx  = in_train ? idx : '0;
    assign cur_rep  = in_train ? rep : '0;
    assign in_ready = !active;
    assign tr       = pat_word(int'(cur_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            pending  <= 1'b0;
            in_train <= 1'b0;
            idx      <= '0;
            rep      <= '0;
        end else if (active) begin
            pending <= 1'b0;
            if (cur_idx == IDX_LAST) begin
                idx <= '0;
                if (cur_rep == cfg_alpha) begin
                    in_train <= 1'b0;
                    rep      <= '0;
                    cnt      <= '0;
                end else begin
                    in_train <= 1'b1;
                    rep      <= cur_rep + ALPHA_W'(1);
                end
            end else begin
                in_train <= 1'b1;
                idx      <= cur_idx + IDX_W'(1);
                rep      <= cur_rep;
            end
        end else if (cfg_max_t == '0) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (!pending) begin
            if (cnt >= cfg_max_t - MAXT_W'(1)) begin
                pending <= 1'b1;
                cnt     <= '0;
            end else begin
                cnt <= cnt + MAXT_W'(1);
            end
        end
    end
endmodule

// File: rtl/dip_corrupt.sv
module dip_corrupt #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_set,
    input  logic [ERR_W-1:0] cfg_err_cnt,
    input  logic             hit,
    output logic             flip,
    output logic             ins_busy
);
    logic [ERR_W-1:0] left;

    assign flip = ins_busy && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_busy <= 1'b0;
            left     <= '0;
        end else if (!ins_busy) begin
            if (ins_set && cfg_err_cnt != '0) begin
                ins_busy <= 1'b1;
                left     <= cfg_err_cnt;
            end
        end else if (hit) begin
            left <= left - ERR_W'(1);
            if (left == ERR_W'(1)) begin
                ins_busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lane_skew.sv
module lane_skew #(
    parameter int MAX_SKEW = 3,
    parameter int SKEW_W   = $clog2(MAX_SKEW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic [SKEW_W-1:0] dly,
    output logic              bit_out
);
    logic [MAX_SKEW:0] tap;

    assign tap[0] = bit_in;

    for (genvar k = 1; k <= MAX_SKEW; k++) begin : g_stage
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= tap[k-1];
        end
        assign tap[k] = q;
    end

    assign bit_out = tap[dly];
endmodule

// File: rtl/egress_train_inj.sv
module egress_train_inj
    import trn_pkg::*;
#(
    parameter int ALPHA_W  = 8,
    parameter int MAXT_W   = 16,
    parameter int ERR_W    = 4,
    parameter int MAX_SKEW = 3,
    localparam int SKEW_W  = $clog2(MAX_SKEW + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_ctrl,
    input  logic [DATA_W-1:0]  in_word,
    output logic               in_ready,
    input  logic [ALPHA_W-1:0] cfg_alpha,
    input  logic [MAXT_W-1:0]  cfg_max_t,
    input  logic [ERR_W-1:0]   cfg_err_cnt,
    input  logic               ins_set,
    input  logic [SKEW_W-1:0]  cfg_bit_dly,
    output logic               ins_busy,
    output logic               out_valid,
    output logic               out_ctrl,
    output logic               out_train,
    output logic [DATA_W-1:0]  out_word
);
    logic       active;
    lane_word_t tr;
    logic       hit;
    logic       flip;
    lane_word_t nxt;
    logic       nxt_v;
    lane_word_t w_q;
    logic       lane0;

    trn_sched #(.ALPHA_W(ALPHA_W), .MAXT_W(MAXT_W)) i_sched (
        .clk      (clk),
        .rst      (rst),
        .cfg_alpha(cfg_alpha),
        .cfg_max_t(cfg_max_t),
        .in_valid (in_valid),
        .in_ctrl  (in_ctrl),
        .active   (active),
        .tr       (tr),
        .in_ready (in_ready)
    );

    assign hit = in_valid && in_ready && in_ctrl;

    dip_corrupt #(.ERR_W(ERR_W)) i_corrupt (
        .clk        (clk),
        .rst        (rst),
        .ins_set    (ins_set),
        .cfg_err_cnt(cfg_err_cnt),
        .hit        (hit),
        .flip       (flip),
        .ins_busy   (ins_busy)
    );

    always_comb begin
        nxt   = '0;
        nxt_v = 1'b0;
        if (active) begin
            nxt   = tr;
            nxt_v = 1'b1;
        end else if (in_valid) begin
            nxt.ctrl = in_ctrl;
            nxt.word = in_word ^ {{(DATA_W-1){1'b0}}, flip};
            nxt_v    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q       <= '0;
            out_valid <= 1'b0;
            out_train <= 1'b0;
        end else begin
            w_q       <= nxt;
            out_valid <= nxt_v;
            out_train <= active;
        end
    end

    lane_skew #(.MAX_SKEW(MAX_SKEW), .SKEW_W(SKEW_W)) i_skew (
        .clk    (clk),
        .rst    (rst),
        .bit_in (w_q.word[0]),
        .dly    (cfg_bit_dly),
        .bit_out(lane0)
    );

    assign out_ctrl = w_q.ctrl;
    assign out_word = {w_q.word[DATA_W-1:1], lane0};
endmodule

// File: rtl/egress_train_inj_chk.sv
module egress_train_inj_chk #(
    parameter int HI_W   = 15,
    parameter int MAXT_W = 16,
    parameter int ERR_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ctrl,
    input logic [HI_W-1:0]   in_hi,
    input logic              in_ready,
    input logic [MAXT_W-1:0] cfg_max_t,
    input logic [ERR_W-1:0]  cfg_err_cnt,
    input logic              ins_set,
    input logic              ins_busy,
    input logic              out_valid,
    input logic              out_ctrl,
    input logic              out_train,
    input logic [HI_W-1:0]   out_hi
);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> out_train);

    p_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !out_train &&
            out_ctrl == $past(in_ctrl) && out_hi == $past(in_hi)));

    p_arm_r6: assert property (@(posedge clk) disable iff (rst)
        (ins_set && !ins_busy && cfg_err_cnt != '0) |=> ins_busy);

    p_busy_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(ins_busy) |-> (out_valid && out_ctrl && !out_train));

    p_zero_cnt_r7: assert property (@(posedge clk) disable iff (rst)
        (ins_set && !ins_busy && cfg_err_cnt == '0) |=> !ins_busy);

    p_no_train_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_max_t == '0 && $past(cfg_max_t) == '0 && !out_train) |=> !out_train);
endmodule

bind egress_train_inj egress_train_inj_chk #(
    .HI_W  (trn_pkg::DATA_W - 1),
    .MAXT_W(MAXT_W),
    .ERR_W (ERR_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ctrl    (in_ctrl),
    .in_hi      (in_word[trn_pkg::DATA_W-1:1]),
    .in_ready   (in_ready),
    .cfg_max_t  (cfg_max_t),
    .cfg_err_cnt(cfg_err_cnt),
    .ins_set    (ins_set),
    .ins_busy   (ins_busy),
    .out_valid  (out_valid),
    .out_ctrl   (out_ctrl),
    .out_train  (out_train),
    .out_hi     (out_word[trn_pkg::DATA_W-1:1])
);

// File: tb/test_egress_train_inj.sv
`timescale 1ns/1ps
module test_egress_train_inj;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_ctrl = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_ready;
    logic [7:0]  cfg_alpha = '0;
    logic [15:0] cfg_max_t = '0;
    logic [3:0]  cfg_err_cnt = '0;
    logic        ins_set = 1'b0;
    logic [1:0]  cfg_bit_dly = '0;
    logic        ins_busy, out_valid, out_ctrl, out_train;
    logic [15:0] out_word;

    always #2.5 clk = ~clk;

    egress_train_inj i_egress_train_inj (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_word(in_word), .in_ready(in_ready), .cfg_alpha(cfg_alpha),
        .cfg_max_t(cfg_max_t), .cfg_err_cnt(cfg_err_cnt), .ins_set(ins_set),
        .cfg_bit_dly(cfg_bit_dly), .ins_busy(ins_busy), .out_valid(out_valid),
        .out_ctrl(out_ctrl), .out_train(out_train), .out_word(out_word)
    );

    int errors = 0, checks = 0;
    bit done = 1'b0;
    logic [16:0] q[$];
    int m_left = 0;
    int m_dly = 0;
    logic [2:0] m_hist = '0;
    int stalls = 0;

    // monitor state
    bit prev_train = 1'b0, seen_end = 1'b0, after_train = 1'b0, chk_bnd = 1'b0;
    int tpos = 0, gap_cnt = 0, last_gap = -1, last_len = -1, bursts = 0, train_total = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic send(input logic c, input logic [15:0] w);
        logic [15:0] raw, ex;
        @(negedge clk);
        in_valid = 1'b1; in_ctrl = c; in_word = w;
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        raw = w;
        if (c && m_left > 0) begin
            raw[0] = ~raw[0];
            m_left--;
        end
        ex = raw;
        if (m_dly != 0) ex[0] = m_hist[m_dly-1];
        m_hist = {m_hist[1:0], raw[0]};
        q.push_back({c, ex});
    endtask

    task automatic quiet();
        @(negedge clk);
        in_valid = 1'b0; in_ctrl = 1'b0; in_word = '0;
        #1;
    endtask

    task automatic arm(input int n);
        @(negedge clk);
        cfg_err_cnt = 4'(n); ins_set = 1'b1;
        if (!ins_busy) m_left = n;
        @(negedge clk);
        ins_set = 1'b0;
        #1;
    endtask

    // Scoreboard monitor and training pattern checker
    always @(negedge clk) begin
        if (!rst) begin
            if (out_train) begin
                int p;
                logic [15:0] ew;
                logic ec;
                if (!prev_train) begin
                    tpos = 0;
                    if (seen_end) last_gap = gap_cnt;
                    bursts++;
                end
                p  = tpos % 21;
                ec = (p <= 10);
                ew = (p == 0) ? 16'h0F0F : (p <= 10) ? 16'h0FFF : 16'hF000;
                chk(out_valid && out_ctrl == ec && out_word == ew,
                    "R3/R8 training word", {out_ctrl, out_word}, {ec, ew});
                tpos++;
                train_total++;
            end else begin
                if (prev_train) begin
                    last_len = tpos;
                    seen_end = 1'b1;
                    gap_cnt = 1;
                    after_train = 1'b1;
                end else begin
                    gap_cnt++;
                end
                if (out_valid) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R10 unexpected word", {out_ctrl, out_word}, 0);
                    end else begin
                        logic [16:0] e;
                        e = q.pop_front();
                        chk({out_ctrl, out_word} == e, "R10/R6/R9 scoreboard word",
                            {out_ctrl, out_word}, e);
                    end
                    if (after_train && chk_bnd)
                        chk(out_ctrl, "R4 first word after burst is control", out_ctrl, 1);
                    after_train = 1'b0;
                end
            end
            prev_train = out_train;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(out_valid == 0 && out_ctrl == 0 && out_train == 0, "R1 out flags", {out_valid, out_ctrl, out_train}, 0);
        chk(out_word == 16'h0, "R1 out_word", out_word, 0);
        chk(ins_busy == 0 && in_ready == 1, "R1 busy/ready", {ins_busy, in_ready}, 1);

        // R10 pass-through, R5 no training when disabled
        send(1'b1, 16'h1235); send(1'b0, 16'hABCD); send(1'b0, 16'h5A5B);
        send(1'b1, 16'h8001); send(1'b0, 16'h0000);
        quiet();
        tick(100);
        chk(train_total == 0, "R5 no training with period 0", train_total, 0);

        // R2 and R3 with alpha=1
        seen_end = 1'b0;
        cfg_alpha = 8'd1; cfg_max_t = 16'd40;
        b0 = bursts;
        while (bursts < b0 + 3) tick(1);
        while (out_train) tick(1);
        cfg_max_t = 16'd0;
        chk(last_len == 42, "R3 burst length alpha=1", last_len, 42);
        chk(last_gap == 40, "R2 gap between bursts", last_gap, 40);
        tick(60);

        // R3 alpha=2
        cfg_alpha = 8'd2; cfg_max_t = 16'd30;
        b0 = bursts;
        while (bursts == b0) tick(1);
        while (out_train) tick(1);
        cfg_max_t = 16'd0;
        chk(last_len == 63, "R3 burst length alpha=2", last_len, 63);
        tick(60);

        // R4 continuous packets, bursts at control boundaries
        cfg_alpha = 8'd0; cfg_max_t = 16'd20; chk_bnd = 1'b1;
        b0 = bursts; stalls = 0;
        for (int pk = 0; pk < 12; pk++) begin
            send(1'b1, 16'h4000 + 16'(pk));
            for (int d = 0; d < 4; d++) send(1'b0, 16'h2000 + 16'(pk * 8 + d));
        end
        quiet();
        chk(stalls > 0, "R4 source held during training", stalls, 1);
        chk(bursts > b0, "R4 bursts inserted in stream", bursts - b0, 1);
        cfg_max_t = 16'd0;
        tick(40);
        chk_bnd = 1'b0;

        // R6 insertion of three errors
        arm(3);
        chk(ins_busy == 1, "R6 busy after arm", ins_busy, 1);
        send(1'b0, 16'h1111); send(1'b1, 16'h2222); send(1'b0, 16'h3333);
        send(1'b1, 16'h4445); send(1'b1, 16'h5556); send(1'b1, 16'h6667);
        send(1'b1, 16'h7778);
        quiet();
        tick(2);
        chk(ins_busy == 0, "R6 busy clears after count", ins_busy, 0);
        chk(m_left == 0, "R6 model count used", m_left, 0);

        // R7 zero count
        arm(0);
        chk(ins_busy == 0, "R7 busy stays low with count 0", ins_busy, 0);
        send(1'b1, 16'h9999); send(1'b1, 16'hAAAA);
        quiet();
        tick(4);

        // R8 armed insertion waits through a burst
        cfg_max_t = 16'd25; cfg_alpha = 8'd0;
        arm(2);
        b0 = bursts;
        while (bursts == b0) tick(1);
        while (out_train) tick(1);
        chk(ins_busy == 1, "R8 insertion survives burst", ins_busy, 1);
        send(1'b1, 16'hC001); send(1'b1, 16'hC002); send(1'b1, 16'hC003);
        quiet();
        tick(2);
        chk(ins_busy == 0, "R8 insertion done after source words", ins_busy, 0);

        // R8 burst start meets a control word with an insertion pending
        arm(5);
        b0 = bursts; stalls = 0;
        for (int pk = 0; pk < 20; pk++) begin
            send(1'b1, 16'h6100 + 16'(pk));
            send(1'b0, 16'h7200 + 16'(pk));
        end
        quiet();
        chk(stalls > 0 && bursts > b0, "R8 collision provoked", stalls, 1);
        cfg_max_t = 16'd0;
        tick(40);

        // R9 lane-0 delay for each setting
        for (int d = 0; d < 4; d++) begin
            cfg_bit_dly = 2'(d);
            m_dly = d;
            tick(6);
            m_hist = '0;
            send(1'b0, 16'h0001); send(1'b0, 16'h0002); send(1'b0, 16'h0003);
            send(1'b0, 16'h0001); send(1'b0, 16'h0000); send(1'b0, 16'h0001);
            send(1'b0, 16'h0000); send(1'b0, 16'h0000);
            quiet();
            tick(6);
        end
        cfg_bit_dly = 2'd0; m_dly = 0;

        tick(10);
        chk(q.size() == 0, "R10 all words delivered", q.size(), 0);
        finish_run();
    end
endmodule